// File: doc/BRIEF.md
# Host Command Mailbox with Status Byte

This block is the byte-wide meeting point between a host processor and an embedded controller. The host uses a pair of I/O addresses. A write to the command address drops a command byte into the mailbox, and a write to the data address drops a data byte. A read of the data address returns the byte the controller last posted. A read of the command address returns a status byte that tells the host what state the exchange is in.

The controller side sees the held byte and a flag that says whether it came in as a command. It consumes the byte with a one-cycle take strobe. It marks command processing with separate set and clear inputs, and it answers by posting a response byte. Two event-pending inputs are passed straight into the status byte. If the host writes again before the controller has taken the previous byte, the new byte replaces the old one and a sticky overrun flag rises, which only reset clears.

Top module: `hmbx_top`

## Requirements
- R1: After reset the status byte reads 0x00, busy is low and the overrun flag is low.
- R2: A host write to the data address (default 0x62) sets status bit 1 and clears status bit 3 on the next cycle. The written byte then appears on the controller's byte output, and the command flag reads 0.
- R3: A host write to the command address (default 0x66) sets status bits 1 and 3 on the next cycle, and the command flag reads 1.
- R4: A take strobe clears status bit 1 on the next cycle. If a host write arrives in the same cycle as the take, bit 1 stays set, the new byte is held and no overrun is flagged.
- R5: Status bit 2 (processing) is set by the set input and cleared by the clear input. When both are asserted in the same cycle, set wins.
- R6: The busy output equals status bit 1 OR status bit 2.
- R7: A post strobe loads the response byte and sets status bit 0. A host read of the data address returns that byte and clears bit 0 on the next cycle. A post in the same cycle as that read leaves bit 0 set.
- R8: Status bit 5 follows the SCI-pending input and bit 6 follows the SMI-pending input. Bits 4 and 7 always read 0.
- R9: A host write while bit 1 is set and no take is present overwrites the held byte and sets the overrun flag. The flag stays set until reset.
- R10: Reads or writes to any other address change no state and read back 0x00.
- R11: A status read (read of the command address) has no side effect on any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (status or response), 0 when no hit |
| ctl_in_byte | output | 8 | Byte held for the controller |
| ctl_in_is_cmd | output | 1 | Held byte came through the command address |
| ctl_in_full | output | 1 | Held byte not yet taken |
| ctl_take | input | 1 | Controller consumes the held byte |
| ctl_proc_set | input | 1 | Start processing |
| ctl_proc_clr | input | 1 | End processing |
| ctl_post | input | 1 | Post a response byte |
| ctl_post_byte | input | 8 | Response byte |
| ctl_overrun | output | 1 | Sticky overwrite flag |
| sci_pend | input | 1 | SCI event pending |
| smi_pend | input | 1 | SMI event pending |
| busy | output | 1 | Host write unconsumed or command in progress |

## Verification
The bench builds the block with its default parameters: a 16-bit address and the port pair 0x62/0x66. These defaults place the neighbouring addresses 0x63 and 0x65 directly beside the decoded pair, so the decode-miss cases test addresses one off from real hits. They also allow every same-cycle collision to be driven at the ports: take with a write, post with a data read, and set with clear.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;
    localparam int BYTE_W = 8;

    // status byte bit positions (host software decodes these)
    localparam int ST_OUT_FULL = 0;
    localparam int ST_IN_FULL  = 1;
    localparam int ST_PROC     = 2;
    localparam int ST_WAS_CMD  = 3;
    localparam int ST_BURST    = 4;
    localparam int ST_SCI      = 5;
    localparam int ST_SMI      = 6;
    localparam int ST_RSVD     = 7;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              full;
        logic              is_cmd;
        logic              ovr;
    } inbox_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              full;
    } outbox_t;
endpackage

// File: rtl/hmbx_decode.sv
module hmbx_decode #(
    parameter int ADDR_W    = 16,
    parameter int CMD_PORT  = 'h66,
    parameter int DATA_PORT = 'h62
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_cmd,
    output logic              wr_data,
    output logic              rd_cmd,
    output logic              rd_data
);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_PORT);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_PORT);

    logic hit_cmd, hit_data;

    always_comb begin
        hit_cmd = (addr == CMD_A);
        hit_data = (addr == DATA_A);
        wr_cmd = wr & hit_cmd;
        wr_data = wr & hit_data;
        rd_cmd = rd & hit_cmd;
        rd_data = rd & hit_data;
    end
endmodule

// File: rtl/hmbx_inbox.sv
module hmbx_inbox
    import hmbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              take,
    output inbox_t            state
);
    inbox_t in_d, in_q;

    always_comb begin
        in_d = in_q;
        if (take) begin
            in_d.full = 1'b0;
        end
        if (wr_cmd || wr_data) begin
            in_d.data = wdata;
            in_d.is_cmd = wr_cmd;
            in_d.full = 1'b1;
            if (in_q.full && !take) begin
                in_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= '0;
        end else begin
            in_q <= in_d;
        end
    end

    assign state = in_q;
endmodule

// File: rtl/hmbx_outbox.sv
module hmbx_outbox
    import hmbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post,
    input  logic [BYTE_W-1:0] post_byte,
    input  logic              host_read,
    output outbox_t           state
);
    outbox_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (host_read) begin
            out_d.full = 1'b0;
        end
        if (post) begin
            out_d.data = post_byte;
            out_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign state = out_q;
endmodule

// File: rtl/hmbx_status.sv
module hmbx_status
    import hmbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_set,
    input  logic              proc_clr,
    input  logic              in_full,
    input  logic              in_is_cmd,
    input  logic              out_full,
    input  logic              sci,
    input  logic              smi,
    output logic              proc,
    output logic [BYTE_W-1:0] status
);
    logic proc_d, proc_q;

    always_comb begin
        proc_d = proc_q;
        if (proc_set) begin
            proc_d = 1'b1;
        end else if (proc_clr) begin
            proc_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proc_q <= 1'b0;
        end else begin
            proc_q <= proc_d;
        end
    end

    always_comb begin
        status = '0;
        status[ST_OUT_FULL] = out_full;
        status[ST_IN_FULL] = in_full;
        status[ST_PROC] = proc_q;
        status[ST_WAS_CMD] = in_is_cmd;
        status[ST_BURST] = 1'b0;
        status[ST_SCI] = sci;
        status[ST_SMI] = smi;
        status[ST_RSVD] = 1'b0;
    end

    assign proc = proc_q;
endmodule

// File: rtl/hmbx_top.sv
module hmbx_top
    import hmbx_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CMD_PORT  = 'h66,
    parameter int DATA_PORT = 'h62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [7:0]        ctl_in_byte,
    output logic              ctl_in_is_cmd,
    output logic              ctl_in_full,
    input  logic              ctl_take,
    input  logic              ctl_proc_set,
    input  logic              ctl_proc_clr,
    input  logic              ctl_post,
    input  logic [7:0]        ctl_post_byte,
    output logic              ctl_overrun,
    input  logic              sci_pend,
    input  logic              smi_pend,
    output logic              busy
);
    logic wr_cmd, wr_data, rd_cmd, rd_data;
    logic wr_hit;
    inbox_t in_s;
    outbox_t out_s;
    logic proc;
    logic [BYTE_W-1:0] status;

    hmbx_decode #(
        .ADDR_W(ADDR_W), .CMD_PORT(CMD_PORT), .DATA_PORT(DATA_PORT)
    ) i_decode (
        .addr(host_addr), .wr(host_wr), .rd(host_rd),
        .wr_cmd(wr_cmd), .wr_data(wr_data), .rd_cmd(rd_cmd), .rd_data(rd_data)
    );

    hmbx_inbox i_inbox (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_data(wr_data),
        .wdata(host_wdata), .take(ctl_take), .state(in_s)
    );

    hmbx_outbox i_outbox (
        .clk(clk), .rst_n(rst_n), .post(ctl_post), .post_byte(ctl_post_byte),
        .host_read(rd_data), .state(out_s)
    );

    hmbx_status i_status (
        .clk(clk), .rst_n(rst_n), .proc_set(ctl_proc_set), .proc_clr(ctl_proc_clr),
        .in_full(in_s.full), .in_is_cmd(in_s.is_cmd), .out_full(out_s.full),
        .sci(sci_pend), .smi(smi_pend), .proc(proc), .status(status)
    );

    always_comb begin
        wr_hit = wr_cmd | wr_data;
        if (rd_cmd) begin
            host_rdata = status;
        end else if (rd_data) begin
            host_rdata = out_s.data;
        end else begin
            host_rdata = '0;
        end
    end

    assign ctl_in_byte = in_s.data;
    assign ctl_in_is_cmd = in_s.is_cmd;
    assign ctl_in_full = in_s.full;
    assign ctl_overrun = in_s.ovr;
    assign busy = in_s.full | proc;
endmodule

// File: rtl/hmbx_checker.sv
module hmbx_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_hit,
    input logic take,
    input logic in_full,
    input logic proc_set,
    input logic proc,
    input logic post,
    input logic out_full,
    input logic ovr
);
    assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> in_full);

    assert_take_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_hit) |=> !in_full);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        proc_set |=> proc);

    assert_post_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> out_full);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> ovr);
endmodule

bind hmbx_top hmbx_checker i_chk (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .take(ctl_take),
    .in_full(ctl_in_full), .proc_set(ctl_proc_set), .proc(proc),
    .post(ctl_post), .out_full(out_s.full), .ovr(ctl_overrun)
);

// File: tb/test_hmbx_top.sv
module test_hmbx_top;
    localparam logic [15:0] A_CMD  = 16'h0066;
    localparam logic [15:0] A_DATA = 16'h0062;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] ctl_in_byte;
    logic ctl_in_is_cmd, ctl_in_full, ctl_overrun, busy;
    logic ctl_take = 1'b0, ctl_proc_set = 1'b0, ctl_proc_clr = 1'b0, ctl_post = 1'b0;
    logic [7:0] ctl_post_byte = '0;
    logic sci_pend = 1'b0, smi_pend = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hmbx_top i_hmbx_top (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ctl_in_byte(ctl_in_byte), .ctl_in_is_cmd(ctl_in_is_cmd),
        .ctl_in_full(ctl_in_full), .ctl_take(ctl_take), .ctl_proc_set(ctl_proc_set),
        .ctl_proc_clr(ctl_proc_clr), .ctl_post(ctl_post), .ctl_post_byte(ctl_post_byte),
        .ctl_overrun(ctl_overrun), .sci_pend(sci_pend), .smi_pend(smi_pend), .busy(busy)
    );

    // op codes: 0 data write, 1 command write, 2 take, 3 post
    // entry = {op, byte, expected status after the op}
    localparam logic [19:0] VEC [7] = '{
        {4'd0, 8'h11, 8'h02},
        {4'd2, 8'h00, 8'h00},
        {4'd1, 8'h84, 8'h0A},
        {4'd2, 8'h00, 8'h08},
        {4'd3, 8'h5A, 8'h09},
        {4'd0, 8'h22, 8'h03},
        {4'd2, 8'h00, 8'h01}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic host_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pulse_take();
        @(negedge clk); ctl_take = 1'b1;
        @(negedge clk); ctl_take = 1'b0;
    endtask

    task automatic pulse_post(input logic [7:0] d);
        @(negedge clk); ctl_post = 1'b1; ctl_post_byte = d;
        @(negedge clk); ctl_post = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] st;
        logic [7:0] rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        host_read(A_CMD, st);
        check("R1 status", st, 8'h00);
        check("R1 busy", {7'd0, busy}, 8'h00);
        check("R1 overrun", {7'd0, ctl_overrun}, 8'h00);

        // vector walk (R2 R3 R4 R7)
        for (int i = 0; i < 7; i++) begin
            case (VEC[i][19:16])
                4'd0: host_write(A_DATA, VEC[i][15:8]);
                4'd1: host_write(A_CMD, VEC[i][15:8]);
                4'd2: pulse_take();
                default: pulse_post(VEC[i][15:8]);
            endcase
            host_read(A_CMD, st);
            check("R2/R3/R4/R7 vector status", st, VEC[i][7:0]);
        end

        // R2 byte and flag seen by controller
        host_write(A_DATA, 8'hA5);
        check("R2 ctl byte", ctl_in_byte, 8'hA5);
        check("R2 ctl is_cmd", {7'd0, ctl_in_is_cmd}, 8'h00);
        pulse_take();
        // R3 command flag
        host_write(A_CMD, 8'hD2);
        check("R3 ctl is_cmd", {7'd0, ctl_in_is_cmd}, 8'h01);
        check("R3 ctl byte", ctl_in_byte, 8'hD2);
        pulse_take();

        // R11: outbox still full from vectors; status reads must not clear bit0
        host_read(A_CMD, st);
        host_read(A_CMD, st);
        check("R11 status read no side effect", st & 8'h01, 8'h01);
        // R7 data read returns posted byte and clears bit0
        host_read(A_DATA, rb);
        check("R7 data read byte", rb, 8'h5A);
        host_read(A_CMD, st);
        check("R7 bit0 cleared", st & 8'h01, 8'h00);
        // R7 post in the same cycle as data read keeps bit0
        pulse_post(8'h77);
        @(negedge clk);
        host_addr = A_DATA; host_rd = 1'b1; ctl_post = 1'b1; ctl_post_byte = 8'h78;
        #1 rb = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; ctl_post = 1'b0;
        check("R7 read during post old byte", rb, 8'h77);
        host_read(A_CMD, st);
        check("R7 post wins over read", st & 8'h01, 8'h01);
        host_read(A_DATA, rb);
        check("R7 new byte", rb, 8'h78);

        // R4 take and write in same cycle
        host_write(A_DATA, 8'h10);
        @(negedge clk);
        host_addr = A_DATA; host_wdata = 8'h20; host_wr = 1'b1; ctl_take = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; ctl_take = 1'b0;
        check("R4 full kept", {7'd0, ctl_in_full}, 8'h01);
        check("R4 new byte", ctl_in_byte, 8'h20);
        check("R4 no overrun", {7'd0, ctl_overrun}, 8'h00);
        pulse_take();
        check("R4 take clears", {7'd0, ctl_in_full}, 8'h00);

        // R5 / R6 processing and busy
        @(negedge clk); ctl_proc_set = 1'b1;
        @(negedge clk); ctl_proc_set = 1'b0;
        check("R6 busy while processing", {7'd0, busy}, 8'h01);
        host_read(A_CMD, st);
        check("R5 proc bit", st & 8'h04, 8'h04);
        @(negedge clk); ctl_proc_set = 1'b1; ctl_proc_clr = 1'b1;
        @(negedge clk); ctl_proc_set = 1'b0; ctl_proc_clr = 1'b0;
        host_read(A_CMD, st);
        check("R5 set wins", st & 8'h04, 8'h04);
        @(negedge clk); ctl_proc_clr = 1'b1;
        @(negedge clk); ctl_proc_clr = 1'b0;
        check("R6 busy idle", {7'd0, busy}, 8'h00);
        host_write(A_DATA, 8'h01);
        check("R6 busy on unconsumed write", {7'd0, busy}, 8'h01);
        pulse_take();

        // R8 event bits, burst and reserved zero
        sci_pend = 1'b1; smi_pend = 1'b1;
        host_read(A_CMD, st);
        check("R8 event bits", st & 8'hF0, 8'h60);
        sci_pend = 1'b0;
        host_read(A_CMD, st);
        check("R8 smi only", st & 8'hF0, 8'h40);
        smi_pend = 1'b0;

        // R10 other addresses
        host_write(16'h0063, 8'hEE);
        check("R10 write miss full", {7'd0, ctl_in_full}, 8'h00);
        check("R10 write miss byte", ctl_in_byte, 8'h01);
        host_read(16'h0065, rb);
        check("R10 read miss", rb, 8'h00);
        host_read(A_CMD, st);
        check("R10 status unchanged", st, 8'h00);

        // R9 overrun
        host_write(A_DATA, 8'h33);
        host_write(A_CMD, 8'h44);
        check("R9 overwrite byte", ctl_in_byte, 8'h44);
        check("R9 overrun set", {7'd0, ctl_overrun}, 8'h01);
        pulse_take();
        repeat (3) @(negedge clk);
        check("R9 overrun sticky", {7'd0, ctl_overrun}, 8'h01);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 overrun cleared by reset", {7'd0, ctl_overrun}, 8'h00);

        finish_run();
    end
endmodule